// File: doc/BRIEF.md
# Paged Monochrome Display Write Controller

This block drives a 128 by 64 one-bit-per-pixel panel image held in an internal frame memory of eight 128-byte pages. A host reaches three registers over a simple 32-bit write port: a mode register, an instruction register and a data register. Two special mode words choose what data-register writes mean. In command mode they are page-select commands. In data mode they are display bytes. Any other mode word turns data-register writes off.

In data mode each byte goes into the current page at the current column offset. The offset then steps by one and wraps inside the page. Selecting a page, whether through the instruction register or through a command, also sets the column offset back to zero.

A separate read port takes a pixel coordinate and returns the pixel one clock later. With it come red, green and blue intensities. These come from a fixed pale foreground colour scaled by a 3-bit brightness level, which arrives on three single-bit input lines.

Top module: `mono_panel_ctrl`

## Requirements
- R1: After reset the mode is off (data-register writes are ignored), the page is 0, the column offset is 0 and the sampled brightness is 0.
- R2: Writing 0x00100011 to the mode register (wr_sel = 0) selects data mode.
- R3: Writing 0x00104011 to the mode register selects command mode. In command mode a data-register write (wr_sel = 2) of 0xB0 to 0xB7 sets the page to the value minus 0xB0 and the offset to 0. Any other value written there changes nothing.
- R4: Any other mode-register value selects the off mode. In the off mode, data-register writes change neither the frame memory nor the page nor the offset.
- R5: An instruction-register write (wr_sel = 1) whose full 32-bit value lies in 0xB0 to 0xB7 sets the page to the value minus 0xB0 and the offset to 0, in any mode. Other values are ignored.
- R6: In data mode a data-register write stores wr_data[7:0] at byte address page*128 + offset. The offset then advances by one, from 127 to 0, and the page does not change.
- R7: Pixel (x, y) is bit (y mod 8) of the byte at address x + (y/8)*128. pix_on shows that bit one clock after rd_x and rd_y are sampled.
- R8: For a set pixel, pix_r = pix_g = floor(224*b/7) and pix_b = floor(255*b/7). Here b = {bright_b2, bright_b1, bright_b0} is sampled in the same cycle as the coordinate. A clear pixel gives all three at zero.
- R9: A write with wr_sel = 3 has no effect on mode, page, offset or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 instruction, 2 data, 3 unused |
| wr_data | input | 32 | Write value |
| bright_b0 | input | 1 | Brightness bit 0 |
| bright_b1 | input | 1 | Brightness bit 1 |
| bright_b2 | input | 1 | Brightness bit 2 |
| rd_x | input | 7 | Pixel column to read |
| rd_y | input | 6 | Pixel row to read |
| pix_on | output | 1 | Pixel bit, one cycle after the coordinate |
| pix_r | output | 8 | Red intensity |
| pix_g | output | 8 | Green intensity |
| pix_b | output | 8 | Blue intensity |

## Verification
The assertions assume that a host never writes and reads the same frame byte in the same cycle, because the memory returns the old byte in that case. The stimulus never does this: every read follows the last write by at least one clock. The page and offset properties assume that the register-select code is always one of the four defined values. The bench drives only those values. The full coordinate sweeps cover every pixel while the brightness cycles through all eight levels. The wrap, command, invalid-mode and unused-select cases are then checked at the bytes they could have disturbed.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam logic [31:0] MODE_WORD_DATA = 32'h0010_0011;
  localparam logic [31:0] MODE_WORD_CMD  = 32'h0010_4011;
  localparam logic [31:0] PAGE_CODE_BASE = 32'h0000_00B0;

  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_INSTR = 2'd1;
  localparam logic [1:0] SEL_DATA  = 2'd2;

  localparam logic [7:0] FG_RED   = 8'hE0;
  localparam logic [7:0] FG_GREEN = 8'hE0;
  localparam logic [7:0] FG_BLUE  = 8'hFF;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_CMD  = 2'd1,
    MODE_DATA = 2'd2
  } mode_e;

  function automatic logic [7:0] scale_level(input logic [7:0] c, input logic [2:0] b);
    logic [10:0] prod;
    prod = 11'(c) * 11'(b);
    return 8'(prod / 11'd7);
  endfunction
endpackage

// File: rtl/mpc_cmd_decode.sv
module mpc_cmd_decode
  import mpc_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  localparam int XW = $clog2(COLS),
  localparam int PW = $clog2(PAGES),
  localparam int AW = $clog2(COLS * PAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [1:0]    mode_o,
  output logic [PW-1:0] page_o,
  output logic [XW-1:0] off_o
);
  mode_e         mode_q;
  logic [PW-1:0] page_q;
  logic [XW-1:0] off_q;
  logic          page_hit;
  logic [PW-1:0] page_code;
  logic [31:0]   page_diff;

  assign page_diff = wr_data - PAGE_CODE_BASE;
  assign page_hit  = (wr_data >= PAGE_CODE_BASE) &&
                     (wr_data <= PAGE_CODE_BASE + 32'(PAGES - 1));
  assign page_code = page_diff[PW-1:0];

  assign mem_we    = wr_en && (wr_sel == SEL_DATA) && (mode_q == MODE_DATA);
  assign mem_waddr = AW'(page_q) * AW'(COLS) + AW'(off_q);
  assign mem_wdata = wr_data[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_OFF;
      page_q <= '0;
      off_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_MODE: begin
          if (wr_data == MODE_WORD_DATA)     mode_q <= MODE_DATA;
          else if (wr_data == MODE_WORD_CMD) mode_q <= MODE_CMD;
          else                               mode_q <= MODE_OFF;
        end
        SEL_INSTR: begin
          if (page_hit) begin
            page_q <= page_code;
            off_q  <= '0;
          end
        end
        SEL_DATA: begin
          if (mode_q == MODE_CMD && page_hit) begin
            page_q <= page_code;
            off_q  <= '0;
          end else if (mode_q == MODE_DATA) begin
            off_q <= off_q + XW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign page_o = page_q;
  assign off_o  = off_q;
endmodule

// File: rtl/mpc_frame_mem.sv
module mpc_frame_mem #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end
endmodule

// File: rtl/mpc_pixel_shade.sv
module mpc_pixel_shade
  import mpc_pkg::*;
(
  input  logic [7:0] byte_q,
  input  logic [2:0] bitsel_q,
  input  logic [2:0] level_q,
  output logic       pix_on,
  output logic [7:0] pix_r,
  output logic [7:0] pix_g,
  output logic [7:0] pix_b
);
  logic lit;
  assign lit    = byte_q[bitsel_q];
  assign pix_on = lit;

  always_comb begin
    pix_r = '0;
    pix_g = '0;
    pix_b = '0;
    if (lit) begin
      pix_r = scale_level(FG_RED, level_q);
      pix_g = scale_level(FG_GREEN, level_q);
      pix_b = scale_level(FG_BLUE, level_q);
    end
  end
endmodule

// File: rtl/mono_panel_ctrl.sv
module mono_panel_ctrl #(
  parameter int COLS = 128,
  parameter int ROWS = 64,
  localparam int PAGES = ROWS / 8,
  localparam int DEPTH = COLS * PAGES,
  localparam int AW = $clog2(DEPTH),
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(ROWS),
  localparam int PW = $clog2(PAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          bright_b0,
  input  logic          bright_b1,
  input  logic          bright_b2,
  input  logic [XW-1:0] rd_x,
  input  logic [YW-1:0] rd_y,
  output logic          pix_on,
  output logic [7:0]    pix_r,
  output logic [7:0]    pix_g,
  output logic [7:0]    pix_b
);
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic [1:0]    cur_mode;
  logic [PW-1:0] cur_page;
  logic [XW-1:0] cur_off;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_byte;
  logic [2:0]    bitsel_q;
  logic [2:0]    level_q;

  mpc_cmd_decode #(.COLS(COLS), .PAGES(PAGES)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mode_o(cur_mode), .page_o(cur_page), .off_o(cur_off)
  );

  assign rd_addr = AW'(rd_x) + AW'(rd_y >> 3) * AW'(COLS);

  mpc_frame_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bitsel_q <= '0;
      level_q  <= '0;
    end else begin
      bitsel_q <= rd_y[2:0];
      level_q  <= {bright_b2, bright_b1, bright_b0};
    end
  end

  mpc_pixel_shade u_shade (
    .byte_q(rd_byte), .bitsel_q(bitsel_q), .level_q(level_q),
    .pix_on(pix_on), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );
endmodule

// File: rtl/mpc_checker.sv
module mpc_checker
  import mpc_pkg::*;
#(
  parameter int XW = 7,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [31:0]   wr_data,
  input logic          mem_we,
  input logic [1:0]    cur_mode,
  input logic [PW-1:0] cur_page,
  input logic [XW-1:0] cur_off,
  input logic          pix_on,
  input logic [7:0]    pix_r,
  input logic [7:0]    pix_g,
  input logic [7:0]    pix_b
);
  logic instr_hit;
  assign instr_hit = wr_en && wr_sel == SEL_INSTR &&
                     wr_data >= PAGE_CODE_BASE && wr_data <= PAGE_CODE_BASE + 32'((1 << PW) - 1);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_page == '0 && cur_off == '0 && cur_mode == MODE_OFF));

  assert_offset_step_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (cur_off == $past(cur_off) + XW'(1)) && (cur_page == $past(cur_page)));

  assert_instr_page_R5: assert property (@(posedge clk) disable iff (rst)
    instr_hit |=> (cur_page == $past(wr_data[PW-1:0]) && cur_off == '0));

  assert_off_mode_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_OFF && !instr_hit) |=> ($stable(cur_page) && $stable(cur_off)));

  assert_clear_black_R8: assert property (@(posedge clk) disable iff (rst)
    !pix_on |-> (pix_r == 8'd0 && pix_g == 8'd0 && pix_b == 8'd0));

  assert_blue_ge_red_R8: assert property (@(posedge clk) disable iff (rst)
    pix_on |-> (pix_b >= pix_r && pix_r == pix_g));
endmodule

bind mono_panel_ctrl mpc_checker #(.XW(XW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .mem_we(mem_we), .cur_mode(cur_mode), .cur_page(cur_page), .cur_off(cur_off),
  .pix_on(pix_on), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
);

// File: tb/mono_panel_ctrl_bench.sv
module mono_panel_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        bright_b0 = 1'b0, bright_b1 = 1'b0, bright_b2 = 1'b0;
  logic [6:0]  rd_x = '0;
  logic [5:0]  rd_y = '0;
  logic        pix_on;
  logic [7:0]  pix_r, pix_g, pix_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_mem [1024];
  int m_mode = 0;
  int m_page = 0;
  int m_off = 0;

  always #2 clk = ~clk;

  mono_panel_ctrl u_mono_panel_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bright_b0(bright_b0), .bright_b1(bright_b1), .bright_b2(bright_b2),
    .rd_x(rd_x), .rd_y(rd_y), .pix_on(pix_on), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_mode = 0; m_page = 0; m_off = 0;
  endtask

  // Reference model follows R2..R6 and R9; mode 0 off, 1 command, 2 data.
  task automatic bus_wr(input logic [1:0] sel, input logic [31:0] val);
    bit hit;
    hit = (val >= 32'hB0 && val <= 32'hB7);
    if (sel == 2'd0) m_mode = (val == 32'h0010_0011) ? 2 : (val == 32'h0010_4011) ? 1 : 0;
    else if (sel == 2'd1) begin
      if (hit) begin m_page = int'(val) - 'hB0; m_off = 0; end
    end else if (sel == 2'd2) begin
      if (m_mode == 1 && hit) begin m_page = int'(val) - 'hB0; m_off = 0; end
      else if (m_mode == 2) begin
        m_mem[m_page * 128 + m_off] = val[7:0];
        m_off = (m_off + 1) % 128;
      end
    end
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic read_px(input int x, input int y, input int b);
    rd_x = 7'(x); rd_y = 6'(y);
    {bright_b2, bright_b1, bright_b0} = 3'(b);
    @(negedge clk);
  endtask

  task automatic check_px(input int x, input int y, input int b, input string req);
    bit eon;
    int er, eb;
    read_px(x, y, b);
    eon = m_mem[x + (y / 8) * 128][y % 8];
    er = eon ? (224 * b) / 7 : 0;
    eb = eon ? (255 * b) / 7 : 0;
    chk(pix_on == eon && pix_r == 8'(er) && pix_g == 8'(er) && pix_b == 8'(eb), req,
        {pix_on, pix_r, pix_g, pix_b}, {eon, 8'(er), 8'(er), 8'(eb)});
  endtask

  task automatic check_byte(input int addr, input string req);
    for (int k = 0; k < 8; k++) check_px(addr % 128, (addr / 128) * 8 + k, 7, req);
  endtask

  task automatic sweep(input int salt);
    for (int y = 0; y < 64; y++)
      for (int x = 0; x < 128; x++)
        check_px(x, y, (x + 3 * y + salt) % 8, "R7_R8 sweep");
  endtask

  initial begin
    do_reset();
    // R1: off mode after reset, this write must be dropped
    bus_wr(2'd2, 32'h77);
    // R2: fill every page in data mode
    bus_wr(2'd0, 32'h0010_0011);
    for (int p = 0; p < 8; p++) begin
      bus_wr(2'd1, 32'hB0 + p);
      for (int c = 0; c < 128; c++) bus_wr(2'd2, 32'((p * 37 + c * 11) ^ 'h5A));
    end
    sweep(0);

    // R1: after reset, mode off and page/offset zero
    do_reset();
    bus_wr(2'd2, 32'hEE);
    check_byte(0, "R1 off after reset");
    bus_wr(2'd0, 32'h0010_0011);
    bus_wr(2'd2, 32'h3C);
    check_byte(0, "R1 page0 off0 after reset");
    check_px(2, 2, 0, "R1 R8 level zero gives black");

    // R6: wrap inside page 3, page 4 untouched
    bus_wr(2'd1, 32'hB3);
    for (int i = 0; i < 130; i++) bus_wr(2'd2, 32'(8'h80 + i));
    chk(m_mem[384] == 8'h00 && m_mem[385] == 8'h01, "R6 model wrap", m_mem[384], 0);
    check_byte(384, "R6 wrap byte0");
    check_byte(385, "R6 wrap byte1");
    check_byte(386, "R6 no spill byte2");
    check_byte(512, "R6 next page untouched");

    // R3: command mode page selection and ignored non-page values
    bus_wr(2'd0, 32'h0010_4011);
    bus_wr(2'd2, 32'h42);
    bus_wr(2'd2, 32'hB5);
    bus_wr(2'd2, 32'hB8);
    bus_wr(2'd0, 32'h0010_0011);
    bus_wr(2'd2, 32'hA5);
    check_byte(640, "R3 command page5");
    check_byte(641, "R3 non-page value not stored");

    // R5: out-of-range instruction values ignored
    bus_wr(2'd1, 32'hB2);
    bus_wr(2'd2, 32'h11); bus_wr(2'd2, 32'h22); bus_wr(2'd2, 32'h33);
    bus_wr(2'd1, 32'hB8);
    bus_wr(2'd1, 32'h1B2);
    bus_wr(2'd1, 32'hAF);
    bus_wr(2'd2, 32'h44);
    check_byte(259, "R5 offset kept after bad instr");
    check_byte(256, "R5 page set clears offset");

    // R4: invalid mode word drops data writes
    bus_wr(2'd0, 32'h0010_0012);
    bus_wr(2'd2, 32'hFF); bus_wr(2'd2, 32'h00);
    bus_wr(2'd0, 32'h0010_0011);
    bus_wr(2'd2, 32'h5E);
    check_byte(260, "R4 invalid mode ignored data");
    check_byte(261, "R4 invalid mode no advance");

    // R9: unused select leaves mode and offset alone
    bus_wr(2'd3, 32'h0010_4011);
    bus_wr(2'd3, 32'hB6);
    bus_wr(2'd2, 32'hB1);
    check_byte(261, "R9 unused select ignored");

    sweep(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule